// File: doc/BRIEF.md
# Dual-to-Single Link Pixel Merger

This block takes two pixel links that run in step at one common input rate and folds them into a single output stream at twice that rate. Each input pixel carries a colour-and-sync word and a small field of spare bits. On every input period the pair of pixels is captured together. The output then shows the first link's pixel in the first output cycle and the second link's pixel in the next. The second link's spare bits travel in the same output field that the first link's spare bits use, one slot later.

The block runs on the fast output clock. An input strobe, one fast cycle wide, marks each input period, so both links are sampled on the same edge and any bounded skew between them cannot reorder pixels. The second output link has no job in this mode and is held off. A power-down input and a loss-of-clock input each blank every output at once. After either one clears, the output stays off until a fresh input pair is captured.

Top module: `pixel_merger`

## Requirements
- R1: While reset is asserted, and right after it, `out_en` is 0, `out_pix`, `out_spare` and `out_slot` are 0, and the second-link outputs are 0.
- R2: A `pair_stb` pulse while the block is enabled captures both links' pixel and spare inputs on that edge. In the next cycle `out_en` is 1, `out_slot` is 0 (first link), and `out_pix`/`out_spare` equal the first link's captured values.
- R3: In the cycle after the first-link slot, if no new strobe came, `out_slot` is 1 and `out_pix`/`out_spare` equal the second link's captured pixel and spare bits.
- R4: With no new strobe, the slot keeps alternating 0,1,0,1 and replays the same captured pair.
- R5: A strobe in any cycle restarts the slot at the first link with the newly captured pair, including a strobe in the cycle right after a capture.
- R6: `l2_out_en` and `l2_out_pix` are 0 at all times.
- R7: While `pwr_down` is 1, `out_en`, `out_pix`, `out_spare` and `out_slot` are 0 in that same cycle.
- R8: While `clk_lost` is 1, `out_en`, `out_pix`, `out_spare` and `out_slot` are 0 in that same cycle.
- R9: A strobe that comes while `pwr_down` or `clk_lost` is 1 is ignored. After both clear, the outputs stay 0 until the next strobe is captured.
- R10: Link input changes between strobes have no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock (twice the input pixel rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | 1 blanks all outputs and drops the held pair |
| clk_lost | input | 1 | 1 means the first link's clock is missing; blanks all outputs |
| pair_stb | input | 1 | One-cycle pulse marking an input-period edge |
| l1_pix | input | PIX_W | First-link pixel word |
| l1_spare | input | SPARE_W | First-link spare bits |
| l2_pix | input | PIX_W | Second-link pixel word |
| l2_spare | input | SPARE_W | Second-link spare bits |
| out_pix | output | PIX_W | Merged output pixel word |
| out_spare | output | SPARE_W | Spare bits of the link in the current slot |
| out_en | output | 1 | Output link enabled |
| out_slot | output | 1 | 0 means the first-link slot, 1 the second-link slot |
| l2_out_en | output | 1 | Second output link enable, always 0 |
| l2_out_pix | output | PIX_W | Second output link pixel word, always 0 |

## Verification
The interleave is driven with three kinds of pixel pairs. Distinct words on the two links show whether the slots are swapped. All-ones against all-zeros exposes stuck or merged bits. Different spare values per link show whether the spare field follows its own slot. Back-to-back strobes and long gaps without a strobe separate the restart rule from the free-running toggle. The bench also changes the link inputs between strobes, which shows whether capture is tied to the strobe edge alone. Power-down and clock-loss are raised in the middle of a stream, with strobes sent during the blanking, to show that blanking is immediate and that a stale pair never comes back afterwards.

// File: rtl/merge_pkg.sv
package merge_pkg;
  typedef enum logic {
    SLOT_L1 = 1'b0,
    SLOT_L2 = 1'b1
  } slot_e;
endpackage

// File: rtl/link_latch.sv
module link_latch #(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (cap_en) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import merge_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cap,
  input  logic  dis,
  output slot_e slot_q,
  output logic  valid_q
);
  slot_e slot_d;
  logic  valid_d;

  always_comb begin
    slot_d  = (slot_q == SLOT_L1) ? SLOT_L2 : SLOT_L1;
    valid_d = valid_q;
    if (dis) begin
      slot_d  = SLOT_L1;
      valid_d = 1'b0;
    end else if (cap) begin
      slot_d  = SLOT_L1;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= SLOT_L1;
      valid_q <= 1'b0;
    end else begin
      slot_q  <= slot_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/out_gate.sv
module out_gate
  import merge_pkg::*;
#(
  parameter int PIX_W   = 33,
  parameter int SPARE_W = 2
) (
  input  logic [PIX_W-1:0]   a_pix,
  input  logic [SPARE_W-1:0] a_spare,
  input  logic [PIX_W-1:0]   b_pix,
  input  logic [SPARE_W-1:0] b_spare,
  input  slot_e              slot,
  input  logic               valid,
  input  logic               dis,
  output logic [PIX_W-1:0]   out_pix,
  output logic [SPARE_W-1:0] out_spare,
  output logic               out_en,
  output logic               out_slot
);
  always_comb begin
    out_en    = valid & ~dis;
    out_pix   = '0;
    out_spare = '0;
    out_slot  = 1'b0;
    if (out_en) begin
      out_slot = (slot == SLOT_L2);
      if (slot == SLOT_L2) begin
        out_pix   = b_pix;
        out_spare = b_spare;
      end else begin
        out_pix   = a_pix;
        out_spare = a_spare;
      end
    end
  end
endmodule

// File: rtl/pixel_merger.sv
module pixel_merger
  import merge_pkg::*;
#(
  parameter int PIX_W   = 33,
  parameter int SPARE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_down,
  input  logic               clk_lost,
  input  logic               pair_stb,
  input  logic [PIX_W-1:0]   l1_pix,
  input  logic [SPARE_W-1:0] l1_spare,
  input  logic [PIX_W-1:0]   l2_pix,
  input  logic [SPARE_W-1:0] l2_spare,
  output logic [PIX_W-1:0]   out_pix,
  output logic [SPARE_W-1:0] out_spare,
  output logic               out_en,
  output logic               out_slot,
  output logic               l2_out_en,
  output logic [PIX_W-1:0]   l2_out_pix
);
  localparam int NLINK = 2;
  localparam int WORD  = PIX_W + SPARE_W;

  logic             dis;
  logic             cap;
  logic [WORD-1:0]  lnk_d [NLINK];
  logic [WORD-1:0]  lnk_q [NLINK];
  slot_e            slot_q;
  logic             valid_q;

  assign dis      = pwr_down | clk_lost;
  assign cap      = pair_stb & ~dis;
  assign lnk_d[0] = {l1_spare, l1_pix};
  assign lnk_d[1] = {l2_spare, l2_pix};

  for (genvar g = 0; g < NLINK; g++) begin : g_link
    link_latch #(.W(WORD)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .cap_en(cap),
      .d     (lnk_d[g]),
      .q     (lnk_q[g])
    );
  end

  slot_ctrl u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (cap),
    .dis    (dis),
    .slot_q (slot_q),
    .valid_q(valid_q)
  );

  out_gate #(.PIX_W(PIX_W), .SPARE_W(SPARE_W)) u_gate (
    .a_pix    (lnk_q[0][PIX_W-1:0]),
    .a_spare  (lnk_q[0][WORD-1:PIX_W]),
    .b_pix    (lnk_q[1][PIX_W-1:0]),
    .b_spare  (lnk_q[1][WORD-1:PIX_W]),
    .slot     (slot_q),
    .valid    (valid_q),
    .dis      (dis),
    .out_pix  (out_pix),
    .out_spare(out_spare),
    .out_en   (out_en),
    .out_slot (out_slot)
  );

  assign l2_out_en  = 1'b0;
  assign l2_out_pix = '0;
endmodule

// File: rtl/pixel_merger_chk.sv
module pixel_merger_chk #(
  parameter int PIX_W   = 33,
  parameter int SPARE_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic             clk_lost,
  input logic             pair_stb,
  input logic             out_en,
  input logic             out_slot,
  input logic             l2_out_en,
  input logic [PIX_W-1:0] l2_out_pix,
  input logic [PIX_W-1:0] out_pix
);
  // R6
  a_r6_l2_off: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_out_en == 1'b0) && (l2_out_pix == '0));
  // R7
  a_r7_pd_blank: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!out_en && out_pix == '0));
  // R8
  a_r8_clk_lost_blank: assert property (@(posedge clk) disable iff (!rst_n)
    clk_lost |-> (!out_en && out_pix == '0));
  // R2 / R5
  a_r2_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_stb && !pwr_down && !clk_lost) |=> (!out_en || !out_slot));
  // R3 / R4
  a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !pair_stb) |=> (!out_en || out_slot != $past(out_slot)));
  // R9
  a_r9_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && !pair_stb) |=> !out_en);
endmodule

bind pixel_merger pixel_merger_chk #(.PIX_W(PIX_W), .SPARE_W(SPARE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_down  (pwr_down),
  .clk_lost  (clk_lost),
  .pair_stb  (pair_stb),
  .out_en    (out_en),
  .out_slot  (out_slot),
  .l2_out_en (l2_out_en),
  .l2_out_pix(l2_out_pix),
  .out_pix   (out_pix)
);

// File: tb/tb_pixel_merger.sv
module tb_pixel_merger;
  localparam int PW = 33;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_down = 1'b0;
  logic          clk_lost = 1'b0;
  logic          pair_stb = 1'b0;
  logic [PW-1:0] l1_pix = '0;
  logic [SW-1:0] l1_spare = '0;
  logic [PW-1:0] l2_pix = '0;
  logic [SW-1:0] l2_spare = '0;
  logic [PW-1:0] out_pix;
  logic [SW-1:0] out_spare;
  logic          out_en;
  logic          out_slot;
  logic          l2_out_en;
  logic [PW-1:0] l2_out_pix;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pixel_merger #(.PIX_W(PW), .SPARE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .clk_lost(clk_lost),
    .pair_stb(pair_stb), .l1_pix(l1_pix), .l1_spare(l1_spare),
    .l2_pix(l2_pix), .l2_spare(l2_spare), .out_pix(out_pix),
    .out_spare(out_spare), .out_en(out_en), .out_slot(out_slot),
    .l2_out_en(l2_out_en), .l2_out_pix(l2_out_pix)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic en, input logic slot,
                            input logic [PW-1:0] p, input logic [SW-1:0] s);
    chk({tag, " en"}, 64'(out_en), 64'(en));
    chk({tag, " slot"}, 64'(out_slot), 64'(slot));
    chk({tag, " pix"}, 64'(out_pix), 64'(p));
    chk({tag, " spare"}, 64'(out_spare), 64'(s));
    chk("R6 l2 off", 64'({l2_out_en, l2_out_pix}), 64'd0);
  endtask

  task automatic load(input logic [PW-1:0] a, input logic [SW-1:0] as_,
                      input logic [PW-1:0] b, input logic [SW-1:0] bs);
    l1_pix = a; l1_spare = as_; l2_pix = b; l2_spare = bs;
  endtask

  task automatic t_reset();
    #1;
    expect_out("R1 in reset", 1'b0, 1'b0, '0, '0);
    tick(); tick();
    rst_n = 1'b1;
    tick();
    expect_out("R1 after reset", 1'b0, 1'b0, '0, '0);
  endtask

  task automatic t_interleave(input logic [PW-1:0] a, input logic [SW-1:0] as_,
                              input logic [PW-1:0] b, input logic [SW-1:0] bs);
    load(a, as_, b, bs);
    pair_stb = 1'b1;
    tick();
    pair_stb = 1'b0;
    expect_out("R2 first slot", 1'b1, 1'b0, a, as_);
    load(~a, ~as_, ~b, ~bs);                 // R10 inputs move between strobes
    tick();
    expect_out("R3 second slot", 1'b1, 1'b1, b, bs);
    tick();
    expect_out("R4 replay first", 1'b1, 1'b0, a, as_);
    tick();
    expect_out("R10 replay second", 1'b1, 1'b1, b, bs);
  endtask

  task automatic t_back_to_back();
    load(33'h0_1234_5678, 2'b01, 33'h1_8765_4321, 2'b10);
    pair_stb = 1'b1;
    tick();
    expect_out("R2 b2b first", 1'b1, 1'b0, 33'h0_1234_5678, 2'b01);
    load(33'h0_0BAD_F00D, 2'b11, 33'h1_CAFE_0001, 2'b00);
    tick();
    pair_stb = 1'b0;
    expect_out("R5 restart", 1'b1, 1'b0, 33'h0_0BAD_F00D, 2'b11);
    tick();
    expect_out("R5 then second", 1'b1, 1'b1, 33'h1_CAFE_0001, 2'b00);
  endtask

  task automatic t_blank(input bit use_pd);
    string tg;
    tg = use_pd ? "R7" : "R8";
    load(33'h0_0000_00AA, 2'b10, 33'h0_0000_0055, 2'b01);
    pair_stb = 1'b1;
    tick();
    pair_stb = 1'b0;
    expect_out({tg, " pre"}, 1'b1, 1'b0, 33'h0_0000_00AA, 2'b10);
    if (use_pd) pwr_down = 1'b1; else clk_lost = 1'b1;
    #1;
    expect_out({tg, " blank now"}, 1'b0, 1'b0, '0, '0);
    load(33'h1_FFFF_0000, 2'b11, 33'h0_0F0F_0F0F, 2'b11);
    pair_stb = 1'b1;                          // R9 ignored strobe
    tick();
    pair_stb = 1'b0;
    expect_out({tg, " held blank"}, 1'b0, 1'b0, '0, '0);
    pwr_down = 1'b0; clk_lost = 1'b0;
    tick();
    expect_out("R9 stays off", 1'b0, 1'b0, '0, '0);
    tick();
    expect_out("R9 still off", 1'b0, 1'b0, '0, '0);
    pair_stb = 1'b1;
    tick();
    pair_stb = 1'b0;
    expect_out("R9 resumes", 1'b1, 1'b0, 33'h1_FFFF_0000, 2'b11);
  endtask

  initial begin
    t_reset();
    t_interleave(33'h0_1111_2222, 2'b01, 33'h1_3333_4444, 2'b10);
    t_interleave({PW{1'b1}}, 2'b11, '0, 2'b00);
    t_interleave(33'h0_AAAA_AAAA, 2'b00, 33'h1_5555_5555, 2'b11);
    t_back_to_back();
    t_blank(1'b1);
    t_blank(1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule